// File: doc/BRIEF.md
# Dual Codec Boot and Configuration Sequencer

This block brings two external compression codecs out of reset and into their encoding state with no processor involved. Both codecs hang on one 32-bit asynchronous host register bus. Each codec has its own active-low chip-select, and the two share one write strobe and one read strobe. A single `start` pulse runs a fixed program per codec:

1. Direct writes set up the clock, boot, bus-width and indirect-access registers.
2. A firmware image from an on-chip ROM is streamed through an indirect address/data register pair.
3. A software restart is issued, and the two mode registers are written again.
4. Five encoding parameter words are loaded.
5. A four-step handshake confirms that the firmware is running.

The codecs are handled one after the other. Codec 0 carries luma and codec 1 carries chroma. Each codec gets its own done flag, or its own sticky error flag if its interrupt never arrives or its readback is wrong. An error on one codec does not stop the other from being brought up.

Every bus access holds chip-select and the chosen strobe low for a parameter number of clocks. One idle clock follows each access. With this, the strobe rate can be held under the codec's access limit at any system clock.

Top module: `codec_boot_seq`

## Requirements
- R1: After reset the following hold until `start` is pulsed: both chip-selects high, both strobes high, `busy` low, and `done` and `err` all zero.
- R2: Each codec's program opens with four writes in this order: address 0x0 (clock setup) = 0x00000084, address 0x1 (boot control) = 0x0000008A, address 0x2 (bus width) = 0x0000000A, address 0x3 (indirect access mode) = 0x0000000A.
- R3: Next comes a write of 0x00050000 to address 0x4 (indirect address). It is followed by FW_WORDS writes to address 0x5 (indirect data), where word k is 0x5EED0000 + k.
- R4: After the firmware, address 0x1 is written with 0x0000008D (soft restart). Then addresses 0x2 and 0x3 are each written with 0x0000000A again.
- R5: Address 0x4 is then written with 0x00057F00, followed by five writes to address 0x5. Codec 0 gets 0x02010503, 0x03000000, 0x01019500, 0x00000001, 0x00000000. Codec 1 gets 0x03010503, 0x03000000, 0x01008700, 0x00000001, 0x00000000.
- R6: Firmware check, in order:
  - Write 0x00000400 to address 0x6 (interrupt enable).
  - Wait for that codec's `irq_n` to be low.
  - Read address 0x7 (interrupt flags) and require bit 10 to be set.
  - Read address 0x8 (software flag) and require bits 15:0 = 0xFF82. The upper bits are ignored.
  - Write 0x00000400 to address 0x7.
  - Set that codec's `done` bit.
- R7: Codec 0 finishes or fails completely before any access to codec 1. During a strobe exactly one chip-select is low, and no chip-select is low at any other time.
- R8: Each strobe stays low for exactly STROBE_CYC clocks, and at least one idle clock separates two strobes. `host_we_n` and `host_rd_n` are never low together, and the address and write data stay stable while a strobe is low.
- R9: If `irq_n` is not seen low within IRQ_TIMEOUT clocks of the wait starting, that codec's `err` bit is set and the codec gets no further access. The sequencer then moves on to the next codec.
- R10: An application identifier other than 0xFF82 sets that codec's `err` bit. The final interrupt-flag write is then skipped.
- R11: A flag readback with bit 10 clear sets that codec's `err` bit, even if every other bit is set. The identifier read is then skipped.
- R12: `busy` is high from `start` until both codecs are finished. While `busy` is high, `start` is ignored. `done` and `err` hold their values until the next reset, and a codec never has both bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Single-cycle pulse that begins the bring-up |
| host_cs_n | output | 2 | Active-low chip-selects, bit 0 for codec 0 (luma), bit 1 for codec 1 (chroma) |
| host_we_n | output | 1 | Shared active-low write strobe |
| host_rd_n | output | 1 | Shared active-low read strobe |
| host_addr | output | 4 | Direct register address |
| host_wdata | output | 32 | Write data |
| host_rdata | input | 32 | Read data, sampled on the last clock of a read strobe |
| irq_n | input | 2 | Active-low interrupt pins, one per codec, asynchronous |
| busy | output | 1 | Sequence in progress |
| done | output | 2 | Per-codec bring-up succeeded |
| err | output | 2 | Per-codec sticky failure |

## Verification
The hardest states to reach are the failure exits partway through the firmware handshake. Each one must stop one codec's traffic at a precise point while the other codec still gets its full program. The bench models the two codecs behind the bus with independent readback values and interrupt delays for each device. It withholds the interrupt, corrupts the identifier, or clears only the flag bit on one codec, then compares the per-device access log against the truncated expected sequence. An interrupt delay close to the timeout checks the boundary from the accepting side.

// File: rtl/codec_boot_pkg.sv
package codec_boot_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam int STEP_W = 5;

    // direct register addresses on the host bus
    localparam logic [ADDR_W-1:0] RA_CLK  = 4'h0;
    localparam logic [ADDR_W-1:0] RA_BOOT = 4'h1;
    localparam logic [ADDR_W-1:0] RA_BUS  = 4'h2;
    localparam logic [ADDR_W-1:0] RA_ACC  = 4'h3;
    localparam logic [ADDR_W-1:0] RA_IADR = 4'h4;
    localparam logic [ADDR_W-1:0] RA_IDAT = 4'h5;
    localparam logic [ADDR_W-1:0] RA_IEN  = 4'h6;
    localparam logic [ADDR_W-1:0] RA_IFLG = 4'h7;
    localparam logic [ADDR_W-1:0] RA_SWF  = 4'h8;

    localparam logic [DATA_W-1:0] FW_BASE = 32'h5EED_0000;

    typedef enum logic [2:0] {
        OP_WR,
        OP_RD,
        OP_FW,
        OP_IRQ,
        OP_END
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;   // write value or expected read value
        logic [DATA_W-1:0] mask;   // compared bits on reads
    } step_t;

endpackage

// File: rtl/codec_step_rom.sv
module codec_step_rom
    import codec_boot_pkg::*;
(
    input  logic              dev,
    input  logic [STEP_W-1:0] idx,
    output step_t             step
);
    function automatic step_t wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] v);
        return '{op: OP_WR, addr: a, data: v, mask: '0};
    endfunction

    function automatic step_t rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] v,
                                 input logic [DATA_W-1:0] m);
        return '{op: OP_RD, addr: a, data: v, mask: m};
    endfunction

    always_comb begin
        unique case (idx)
            5'd0:    step = wr(RA_CLK,  32'h0000_0084);
            5'd1:    step = wr(RA_BOOT, 32'h0000_008A);
            5'd2:    step = wr(RA_BUS,  32'h0000_000A);
            5'd3:    step = wr(RA_ACC,  32'h0000_000A);
            5'd4:    step = wr(RA_IADR, 32'h0005_0000);
            5'd5:    step = '{op: OP_FW, addr: RA_IDAT, data: '0, mask: '0};
            5'd6:    step = wr(RA_BOOT, 32'h0000_008D);
            5'd7:    step = wr(RA_BUS,  32'h0000_000A);
            5'd8:    step = wr(RA_ACC,  32'h0000_000A);
            5'd9:    step = wr(RA_IADR, 32'h0005_7F00);
            5'd10:   step = wr(RA_IDAT, dev ? 32'h0301_0503 : 32'h0201_0503);
            5'd11:   step = wr(RA_IDAT, 32'h0300_0000);
            5'd12:   step = wr(RA_IDAT, dev ? 32'h0100_8700 : 32'h0101_9500);
            5'd13:   step = wr(RA_IDAT, 32'h0000_0001);
            5'd14:   step = wr(RA_IDAT, 32'h0000_0000);
            5'd15:   step = wr(RA_IEN,  32'h0000_0400);
            5'd16:   step = '{op: OP_IRQ, addr: '0, data: '0, mask: '0};
            5'd17:   step = rd(RA_IFLG, 32'h0000_0400, 32'h0000_0400);
            5'd18:   step = rd(RA_SWF,  32'h0000_FF82, 32'h0000_FFFF);
            5'd19:   step = wr(RA_IFLG, 32'h0000_0400);
            default: step = '{op: OP_END, addr: '0, data: '0, mask: '0};
        endcase
    end
endmodule

// File: rtl/codec_fw_rom.sv
module codec_fw_rom
    import codec_boot_pkg::*;
#(
    parameter int FW_WORDS = 16,
    parameter int IDX_W    = (FW_WORDS > 1) ? $clog2(FW_WORDS) : 1
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] word
);
    // image contents are computed from the index
    assign word = FW_BASE + DATA_W'(idx);
endmodule

// File: rtl/codec_host_port.sv
module codec_host_port
    import codec_boot_pkg::*;
#(
    parameter int STROBE_CYC = 2,
    parameter int CNT_W      = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_dev,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rsp_data,
    output logic [1:0]        cs_n,
    output logic              we_n,
    output logic              rd_n,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rdata
);
    typedef enum logic [1:0] {P_IDLE, P_STB, P_GAP} ph_e;

    typedef struct packed {
        ph_e               ph;
        logic [CNT_W-1:0]  cnt;
        logic              wr;
        logic              dev;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rsp;
    } port_t;

    port_t q, d;

    always_comb begin
        d = q;
        unique case (q.ph)
            P_IDLE: if (req_valid) begin
                d.ph    = P_STB;
                d.cnt   = CNT_W'(STROBE_CYC - 1);
                d.wr    = req_write;
                d.dev   = req_dev;
                d.addr  = req_addr;
                d.wdata = req_wdata;
            end
            P_STB: begin
                if (q.cnt == '0) begin
                    d.rsp = rdata;
                    d.ph  = P_GAP;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.ph = P_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{ph: P_IDLE, default: '0};
        else        q <= d;
    end

    assign ack      = (q.ph == P_GAP);
    assign rsp_data = q.rsp;
    assign cs_n     = (q.ph == P_STB) ? ~(2'b01 << q.dev) : 2'b11;
    assign we_n     = !((q.ph == P_STB) && q.wr);
    assign rd_n     = !((q.ph == P_STB) && !q.wr);
    assign addr     = q.addr;
    assign wdata    = q.wdata;
endmodule

// File: rtl/codec_boot_seq.sv
module codec_boot_seq
    import codec_boot_pkg::*;
#(
    parameter int FW_WORDS    = 16,
    parameter int STROBE_CYC  = 2,
    parameter int IRQ_TIMEOUT = 1_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic [1:0]  host_cs_n,
    output logic        host_we_n,
    output logic        host_rd_n,
    output logic [3:0]  host_addr,
    output logic [31:0] host_wdata,
    input  logic [31:0] host_rdata,
    input  logic [1:0]  irq_n,
    output logic        busy,
    output logic [1:0]  done,
    output logic [1:0]  err
);
    localparam int FW_IW = (FW_WORDS > 1) ? $clog2(FW_WORDS) : 1;
    localparam int TMO_W = $clog2(IRQ_TIMEOUT + 1);

    typedef enum logic [1:0] {T_IDLE, T_RUN, T_FIN} tst_e;

    typedef struct packed {
        tst_e              st;
        logic              dev;
        logic [STEP_W-1:0] step;
        logic [FW_IW-1:0]  fw;
        logic [TMO_W-1:0]  tmo;
        logic [1:0]        irq_s1;
        logic [1:0]        irq_s2;
        logic [1:0]        done;
        logic [1:0]        err;
    } ctl_t;

    ctl_t q, d;

    step_t             cur;
    logic [DATA_W-1:0] fw_word;
    logic              req_valid, req_write, ack;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata, rsp_data;
    logic              fail, next_dev;

    codec_step_rom u_steps (.dev(q.dev), .idx(q.step), .step(cur));

    codec_fw_rom #(.FW_WORDS(FW_WORDS), .IDX_W(FW_IW)) u_fw (.idx(q.fw), .word(fw_word));

    codec_host_port #(.STROBE_CYC(STROBE_CYC)) u_port (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_dev(q.dev),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .ack(ack), .rsp_data(rsp_data),
        .cs_n(host_cs_n), .we_n(host_we_n), .rd_n(host_rd_n),
        .addr(host_addr), .wdata(host_wdata), .rdata(host_rdata)
    );

    always_comb begin
        d          = q;
        d.irq_s1   = irq_n;
        d.irq_s2   = q.irq_s1;
        req_valid  = 1'b0;
        req_write  = 1'b1;
        req_addr   = cur.addr;
        req_wdata  = cur.data;
        fail       = 1'b0;
        next_dev   = 1'b0;

        unique case (q.st)
            T_IDLE: if (start) begin
                d.st   = T_RUN;
                d.dev  = 1'b0;
                d.step = '0;
                d.fw   = '0;
                d.tmo  = '0;
            end
            T_RUN: begin
                unique case (cur.op)
                    OP_WR: begin
                        req_valid = 1'b1;
                        if (ack) d.step = q.step + 1'b1;
                    end
                    OP_FW: begin
                        req_valid = 1'b1;
                        req_wdata = fw_word;
                        if (ack) begin
                            if (q.fw == FW_IW'(FW_WORDS - 1)) begin
                                d.fw   = '0;
                                d.step = q.step + 1'b1;
                            end else begin
                                d.fw = q.fw + 1'b1;
                            end
                        end
                    end
                    OP_RD: begin
                        req_valid = 1'b1;
                        req_write = 1'b0;
                        if (ack) begin
                            if ((rsp_data & cur.mask) == (cur.data & cur.mask))
                                d.step = q.step + 1'b1;
                            else
                                fail = 1'b1;
                        end
                    end
                    OP_IRQ: begin
                        if (!q.irq_s2[q.dev]) begin
                            d.tmo  = '0;
                            d.step = q.step + 1'b1;
                        end else if (q.tmo == TMO_W'(IRQ_TIMEOUT - 1)) begin
                            fail = 1'b1;
                        end else begin
                            d.tmo = q.tmo + 1'b1;
                        end
                    end
                    default: begin
                        d.done[q.dev] = 1'b1;
                        next_dev      = 1'b1;
                    end
                endcase

                if (fail) begin
                    d.err[q.dev] = 1'b1;
                    next_dev     = 1'b1;
                end
                if (next_dev) begin
                    d.step = '0;
                    d.fw   = '0;
                    d.tmo  = '0;
                    if (q.dev) d.st  = T_FIN;
                    else       d.dev = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: T_IDLE, irq_s1: 2'b11, irq_s2: 2'b11, default: '0};
        else        q <= d;
    end

    assign busy = (q.st == T_RUN);
    assign done = q.done;
    assign err  = q.err;
endmodule

// File: rtl/codec_boot_chk.sv
module codec_boot_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  host_cs_n,
    input logic        host_we_n,
    input logic        host_rd_n,
    input logic [3:0]  host_addr,
    input logic [31:0] host_wdata,
    input logic        busy,
    input logic [1:0]  done,
    input logic [1:0]  err
);
    p_one_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~host_cs_n) <= 1);

    p_cs_with_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs_n != 2'b11) |-> (!host_we_n || !host_rd_n));

    p_no_dual_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!host_we_n && !host_rd_n));

    p_gap_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_we_n) |-> host_rd_n);

    p_stable_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_we_n && $past(!host_we_n)) |-> ($stable(host_addr) && $stable(host_wdata)));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (host_cs_n == 2'b11));

    p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (err != 2'b00) |=> ((err & $past(err)) == $past(err)));

    p_done_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done != 2'b00) |=> ((done & $past(done)) == $past(done)));

    p_done_err_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done & err) == 2'b00);
endmodule

bind codec_boot_seq codec_boot_chk u_chk (
    .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_we_n(host_we_n),
    .host_rd_n(host_rd_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .busy(busy), .done(done), .err(err)
);

// File: tb/tb_codec_boot_seq.sv
module tb_codec_boot_seq;
    localparam int CLK_PERIOD = 10;
    localparam int FW_N       = 8;
    localparam int STB        = 3;
    localparam int TMO        = 200;
    localparam int FULL       = 18 + FW_N;
    localparam int LOG_MAX    = 256;

    // per-device expected accesses without the firmware stream: {write, addr, luma, chroma}
    localparam logic [68:0] TBL [18] = '{
        {1'b1, 4'h0, 32'h0000_0084, 32'h0000_0084},
        {1'b1, 4'h1, 32'h0000_008A, 32'h0000_008A},
        {1'b1, 4'h2, 32'h0000_000A, 32'h0000_000A},
        {1'b1, 4'h3, 32'h0000_000A, 32'h0000_000A},
        {1'b1, 4'h4, 32'h0005_0000, 32'h0005_0000},
        {1'b1, 4'h1, 32'h0000_008D, 32'h0000_008D},
        {1'b1, 4'h2, 32'h0000_000A, 32'h0000_000A},
        {1'b1, 4'h3, 32'h0000_000A, 32'h0000_000A},
        {1'b1, 4'h4, 32'h0005_7F00, 32'h0005_7F00},
        {1'b1, 4'h5, 32'h0201_0503, 32'h0301_0503},
        {1'b1, 4'h5, 32'h0300_0000, 32'h0300_0000},
        {1'b1, 4'h5, 32'h0101_9500, 32'h0100_8700},
        {1'b1, 4'h5, 32'h0000_0001, 32'h0000_0001},
        {1'b1, 4'h5, 32'h0000_0000, 32'h0000_0000},
        {1'b1, 4'h6, 32'h0000_0400, 32'h0000_0400},
        {1'b0, 4'h7, 32'h0000_0000, 32'h0000_0000},
        {1'b0, 4'h8, 32'h0000_0000, 32'h0000_0000},
        {1'b1, 4'h7, 32'h0000_0400, 32'h0000_0400}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  host_cs_n;
    logic        host_we_n, host_rd_n;
    logic [3:0]  host_addr;
    logic [31:0] host_wdata;
    logic [31:0] host_rdata;
    logic [1:0]  irq_n = 2'b11;
    logic        busy;
    logic [1:0]  done, err;

    int n_checks = 0;
    int n_fail   = 0;

    // codec model state
    logic [31:0] flag_val [2];
    logic [31:0] id_val   [2];
    int          irq_delay[2];
    int          irq_cnt  [2];
    logic        log_dev  [LOG_MAX];
    logic        log_wr   [LOG_MAX];
    logic [3:0]  log_addr [LOG_MAX];
    logic [31:0] log_data [LOG_MAX];
    int          n_log;
    int          slen;
    int          strobe_err;
    int          cs_err;
    logic        s_dev, s_wr;
    logic [3:0]  s_addr;
    logic [31:0] s_data;

    always #(CLK_PERIOD / 2) clk = ~clk;

    codec_boot_seq #(.FW_WORDS(FW_N), .STROBE_CYC(STB), .IRQ_TIMEOUT(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .host_cs_n(host_cs_n), .host_we_n(host_we_n), .host_rd_n(host_rd_n),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq_n(irq_n), .busy(busy), .done(done), .err(err)
    );

    always_comb begin
        host_rdata = 32'h0;
        for (int d = 0; d < 2; d++) begin
            if (!host_cs_n[d]) begin
                if (host_addr == 4'h7) host_rdata = flag_val[d];
                if (host_addr == 4'h8) host_rdata = id_val[d];
            end
        end
    end

    // bus observer and interrupt model, active on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            for (int d = 0; d < 2; d++) begin
                if (irq_cnt[d] > 0) irq_cnt[d] = irq_cnt[d] - 1;
                else if (irq_cnt[d] == 0) begin
                    irq_n[d]   = 1'b0;
                    irq_cnt[d] = -1;
                end
            end
            if (!host_we_n || !host_rd_n) begin
                if (host_cs_n != 2'b10 && host_cs_n != 2'b01) cs_err++;
                slen++;
                s_dev  = (host_cs_n == 2'b01);
                s_wr   = !host_we_n;
                s_addr = host_addr;
                s_data = host_wdata;
            end else begin
                if (host_cs_n != 2'b11) cs_err++;
                if (slen > 0) begin
                    if (slen != STB) strobe_err++;
                    if (n_log < LOG_MAX) begin
                        log_dev[n_log]  = s_dev;
                        log_wr[n_log]   = s_wr;
                        log_addr[n_log] = s_addr;
                        log_data[n_log] = s_wr ? s_data : 32'h0;
                        n_log++;
                    end
                    if (s_wr && s_addr == 4'h6 && irq_delay[s_dev] >= 0)
                        irq_cnt[s_dev] = irq_delay[s_dev];
                    slen = 0;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input int k);
        if (k < 4)          return "R2";
        if (k < 5 + FW_N)   return "R3";
        if (k < 8 + FW_N)   return "R4";
        if (k < 14 + FW_N)  return "R5";
        return "R6";
    endfunction

    // compares the access log of one device against the first n_exp expected entries
    task automatic check_dev(input bit dv, input int n_exp, input string req);
        int seen = 0;
        for (int i = 0; i < n_log; i++) begin
            if (log_dev[i] == dv) begin
                logic        e_wr;
                logic [3:0]  e_addr;
                logic [31:0] e_data;
                if (seen < 5 || seen >= 5 + FW_N) begin
                    int t = (seen < 5) ? seen : seen - FW_N;
                    if (t > 17) t = 17;
                    e_wr   = TBL[t][68];
                    e_addr = TBL[t][67:64];
                    e_data = dv ? TBL[t][31:0] : TBL[t][63:32];
                end else begin
                    e_wr   = 1'b1;
                    e_addr = 4'h5;
                    e_data = 32'h5EED_0000 + 32'(seen - 5);
                end
                if (seen < n_exp)
                    chk(log_wr[i] == e_wr && log_addr[i] == e_addr && log_data[i] == e_data,
                        tag_of(seen), {log_wr[i], log_addr[i], log_data[i]}, {e_wr, e_addr, e_data});
                seen++;
            end
        end
        chk(seen == n_exp, req, seen, n_exp);
    endtask

    task automatic reset_dut();
        rst_n = 1'b0;
        start = 1'b0;
        irq_n = 2'b11;
        n_log = 0;
        slen  = 0;
        strobe_err = 0;
        cs_err = 0;
        irq_cnt[0] = -1;
        irq_cnt[1] = -1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_seq(input bit poke_start);
        int cyc = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R12 busy after start", busy, 1);
        while (busy && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (poke_start && cyc == 30) start = 1'b1;
            if (poke_start && cyc == 31) start = 1'b0;
        end
        chk(cyc < 20000, "R12 sequence completes", cyc, 20000);
        repeat (5) @(negedge clk);
    endtask

    task automatic set_codec(input bit dv, input logic [31:0] fl, input logic [31:0] id, input int dly);
        flag_val[dv]  = fl;
        id_val[dv]    = id;
        irq_delay[dv] = dly;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        irq_cnt[0] = -1;
        irq_cnt[1] = -1;
        set_codec(0, 32'h400, 32'hFF82, 10);
        set_codec(1, 32'h400, 32'hFF82, 10);

        // R1: reset state
        reset_dut();
        repeat (10) @(negedge clk);
        chk(host_cs_n == 2'b11 && host_we_n && host_rd_n, "R1 bus idle",
            {host_cs_n, host_we_n, host_rd_n}, 4'hF);
        chk(done == 2'b00 && err == 2'b00 && !busy, "R1 status clear", {busy, done, err}, 0);
        chk(n_log == 0, "R1 no access before start", n_log, 0);

        // nominal bring-up with a second start pulse while busy
        run_seq(1'b1);
        chk(done == 2'b11 && err == 2'b00, "R6 both done", {done, err}, 4'b1100);
        check_dev(1'b0, FULL, "R12 codec0 count, second start ignored");
        check_dev(1'b1, FULL, "R7 codec1 count");
        chk(log_dev[0] == 1'b0 && log_dev[FULL - 1] == 1'b0 && log_dev[FULL] == 1'b1,
            "R7 codec0 before codec1", {log_dev[0], log_dev[FULL - 1], log_dev[FULL]}, 3'b001);
        chk(strobe_err == 0, "R8 strobe width", strobe_err, 0);
        chk(cs_err == 0, "R7 chip-select with strobe only", cs_err, 0);
        repeat (20) @(negedge clk);
        chk(done == 2'b11 && !busy, "R12 done holds", {busy, done}, 3'b011);

        // upper identifier bits ignored, all flag bits set, late interrupt inside the window
        reset_dut();
        set_codec(0, 32'hFFFF_FFFF, 32'h1234_FF82, 10);
        set_codec(1, 32'h400, 32'hFF82, 150);
        run_seq(1'b0);
        chk(done == 2'b11 && err == 2'b00, "R6 masked readback and late irq", {done, err}, 4'b1100);

        // R10: identifier mismatch on codec 0
        reset_dut();
        set_codec(0, 32'h400, 32'hFF83, 10);
        set_codec(1, 32'h400, 32'hFF82, 10);
        run_seq(1'b0);
        chk(err == 2'b01 && done == 2'b10, "R10 id mismatch flags", {done, err}, 4'b1001);
        check_dev(1'b0, 17 + FW_N, "R10 final flag write skipped");
        check_dev(1'b1, FULL, "R10 other codec unaffected");

        // R11: flag bit 10 clear on codec 1
        reset_dut();
        set_codec(0, 32'h400, 32'hFF82, 10);
        set_codec(1, 32'hFFFF_FBFF, 32'hFF82, 10);
        run_seq(1'b0);
        chk(err == 2'b10 && done == 2'b01, "R11 flag bit clear", {done, err}, 4'b0110);
        check_dev(1'b1, 16 + FW_N, "R11 id read skipped");

        // R9: codec 0 never interrupts
        reset_dut();
        set_codec(0, 32'h400, 32'hFF82, -1);
        set_codec(1, 32'h400, 32'hFF82, 10);
        run_seq(1'b0);
        chk(err == 2'b01 && done == 2'b10, "R9 timeout flags", {done, err}, 4'b1001);
        check_dev(1'b0, 15 + FW_N, "R9 no access after timeout");
        check_dev(1'b1, FULL, "R9 next codec proceeds");
        repeat (20) @(negedge clk);
        chk(err == 2'b01, "R12 error sticky", err, 2'b01);
        chk(strobe_err == 0 && cs_err == 0, "R8 strobes in failure runs", strobe_err + cs_err, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule